// File: doc/BRIEF.md
# Clear-on-Read Status Flags with Interrupt

This block gathers the per-sample results of a thermal and fan monitor into two 8-bit status registers. It also drives one active-low interrupt line. The first register, the limit register, holds the high and low limit flags for the local sensor and for each remote sensor. The second register, the event register, holds the fan, diode, critical-limit and external-throttle flags.

Software reads a register by pulsing that register's read strobe. The data ports always show the current flag values. At the clock edge that ends a read cycle, the clearable flags of that register drop.

Each flag follows its own rule for being set again:
- Temperature limit flags are checked again on every monitoring strobe.
- The fan alarm-speed flag reacts only to a fresh entry into alarm speed.
- The tachometer-fault flag sets on every failure pulse.
- The diode-fault flag, once captured at power-up, cannot be cleared by a read.
- A critical-limit flag, once set, is not armed again until its channel has cooled below the hysteresis point.

Per-channel enable bits control both reporting and interrupts. A disabled channel's flags are cleared and stay clear, and the channel raises no interrupt.

Top module: `stat_flag_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, both status registers read zero and `irq_no` is high.
- R2: On a clock with `cycle_i` high, temperature channel k (0 = local, 1.. = remote) with the channel enabled sets `lim_sts_o[2k]` if `temp_hi_i[k]` is high and `lim_sts_o[2k+1]` if `temp_lo_i[k]` is high. After a clear, the flag is set again on the next strobe while the condition holds. The upper, unused bits read zero.
- R3: A clock with `rd_lim_i` high clears every limit-register flag. A clock with `rd_evt_i` high clears every event-register flag except the diode fault. The data shown during the read cycle is the value from before the clear.
- R4: If a flag is set in the same clock in which its register is read, the flag ends up set.
- R5: `evt_sts_o[0]` (alarm speed) is set on a strobe where `fan_alarm_i` is high and was low at the previous strobe. While the alarm stays high, the flag is not set again.
- R6: `evt_sts_o[1]` (fan fault) is set on every clock with `tach_fail_i` high, including pulses that come after a clear.
- R7: `evt_sts_o[2]` (diode fault) is set at the first strobe after reset if `diode_flt_i` is high. After that it is never cleared by reads, it ignores the enables, and it never drives the interrupt.
- R8: `evt_sts_o[3+k]` (critical limit of channel k) is set on a strobe with `crit_over_i[k]` high only while the channel is armed. Setting the flag disarms the channel. A strobe with `crit_cool_i[k]` high arms it again. The channel is armed after reset.
- R9: `evt_sts_o[3+NT]` (external throttle pull, where NT is the number of temperature channels) is set on every clock with `ext_pull_i` high. It is not gated by any enable.
- R10: `chan_en_i[k]` gates temperature channel k, and `chan_en_i[NT]` gates the fan flags. While an enable bit is low, that channel's flags read zero from the next clock onward, they are not set, and they stop driving `irq_no` at once.
- R11: `irq_no` is low exactly when some flag other than the diode fault is set with its channel enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 1 | Monitoring-cycle strobe |
| temp_hi_i | input | NT | High limit exceeded, per temperature channel |
| temp_lo_i | input | NT | Low limit exceeded, per temperature channel |
| crit_over_i | input | NT | Critical limit exceeded, per channel |
| crit_cool_i | input | NT | Below critical limit minus hysteresis, per channel |
| fan_alarm_i | input | 1 | Fan running at alarm speed |
| tach_fail_i | input | 1 | Tachometer failure event pulse |
| diode_flt_i | input | 1 | Remote diode short/open seen at power-up |
| ext_pull_i | input | 1 | Throttle line pulled by an outside agent |
| chan_en_i | input | NT+1 | Channel enables: temperature channels, then fan |
| rd_lim_i | input | 1 | Read strobe, limit register |
| rd_evt_i | input | 1 | Read strobe, event register |
| lim_sts_o | output | 8 | Limit register read data |
| evt_sts_o | output | 8 | Event register read data |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The properties assume that `crit_over_i[k]` and `crit_cool_i[k]` are never high together, since a channel cannot be above the limit and below the hysteresis point at once. They also assume that `NT` is at most four, so that all flags fit in the two registers. The bench drives the over and cool indications of a channel only in separate phases, and it uses the default of two remote channels. Inputs change only between clock edges, so every strobe, read and enable change lines up with exactly one edge.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned ALM_BIT   = 0;
  localparam int unsigned FLT_BIT   = 1;
  localparam int unsigned DIODE_BIT = 2;
  localparam int unsigned CRIT_BASE = 3;

  typedef struct packed {
    logic hi;
    logic lo;
    logic crit;
  } chan_flags_t;
endpackage

// File: rtl/stat_flag_bit.sv
module stat_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set beats clear; disable forces zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (!en_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/stat_temp_chan.sv
module stat_temp_chan
  import stat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cycle_i,
  input  logic        en_i,
  input  logic        hi_i,
  input  logic        lo_i,
  input  logic        crit_i,
  input  logic        cool_i,
  input  logic        clr_lim_i,
  input  logic        clr_evt_i,
  output chan_flags_t flags_o
);
  logic armed_q;
  logic crit_set;

  assign crit_set = cycle_i & crit_i & armed_q & en_i;

  // rearm only after falling through the hysteresis point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 armed_q <= 1'b1;
    else if (crit_set)           armed_q <= 1'b0;
    else if (cycle_i && cool_i)  armed_q <= 1'b1;
  end

  stat_flag_bit u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .set_i(cycle_i & hi_i), .clr_i(clr_lim_i), .q_o(flags_o.hi)
  );

  stat_flag_bit u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .set_i(cycle_i & lo_i), .clr_i(clr_lim_i), .q_o(flags_o.lo)
  );

  stat_flag_bit u_crit (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .set_i(crit_set), .clr_i(clr_evt_i), .q_o(flags_o.crit)
  );
endmodule

// File: rtl/stat_fan_flags.sv
module stat_fan_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_i,
  input  logic en_i,
  input  logic alarm_i,
  input  logic tach_fail_i,
  input  logic clr_i,
  output logic alarm_o,
  output logic fault_o
);
  logic seen_q;
  logic alarm_set;

  // alarm state at previous monitoring sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (cycle_i) seen_q <= alarm_i;
  end

  assign alarm_set = cycle_i & alarm_i & ~seen_q;

  stat_flag_bit u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .set_i(alarm_set), .clr_i(clr_i), .q_o(alarm_o)
  );

  stat_flag_bit u_fault (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .set_i(tach_fail_i), .clr_i(clr_i), .q_o(fault_o)
  );
endmodule

// File: rtl/stat_flag_ctl.sv
module stat_flag_ctl
  import stat_pkg::*;
#(
  parameter int unsigned NUM_REMOTE = 2,
  localparam int unsigned NT = NUM_REMOTE + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_i,
  input  logic [NT-1:0]    temp_hi_i,
  input  logic [NT-1:0]    temp_lo_i,
  input  logic [NT-1:0]    crit_over_i,
  input  logic [NT-1:0]    crit_cool_i,
  input  logic             fan_alarm_i,
  input  logic             tach_fail_i,
  input  logic             diode_flt_i,
  input  logic             ext_pull_i,
  input  logic [NT:0]      chan_en_i,
  input  logic             rd_lim_i,
  input  logic             rd_evt_i,
  output logic [REG_W-1:0] lim_sts_o,
  output logic [REG_W-1:0] evt_sts_o,
  output logic             irq_no
);
  localparam int unsigned FAN_EN  = NT;
  localparam int unsigned EXT_BIT = CRIT_BASE + NT;

  chan_flags_t [NT-1:0] chan_q;
  logic                 alarm_q, fault_q, ext_q;
  logic                 diode_q, pwr_done_q;
  logic [NT-1:0]        temp_irq;

  for (genvar k = 0; k < NT; k++) begin : g_chan
    stat_temp_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cycle_i  (cycle_i),
      .en_i     (chan_en_i[k]),
      .hi_i     (temp_hi_i[k]),
      .lo_i     (temp_lo_i[k]),
      .crit_i   (crit_over_i[k]),
      .cool_i   (crit_cool_i[k]),
      .clr_lim_i(rd_lim_i),
      .clr_evt_i(rd_evt_i),
      .flags_o  (chan_q[k])
    );
    assign temp_irq[k] = chan_en_i[k] &
                         (chan_q[k].hi | chan_q[k].lo | chan_q[k].crit);
  end

  stat_fan_flags u_fan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cycle_i    (cycle_i),
    .en_i       (chan_en_i[FAN_EN]),
    .alarm_i    (fan_alarm_i),
    .tach_fail_i(tach_fail_i),
    .clr_i      (rd_evt_i),
    .alarm_o    (alarm_q),
    .fault_o    (fault_q)
  );

  stat_flag_bit u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1),
    .set_i(ext_pull_i), .clr_i(rd_evt_i), .q_o(ext_q)
  );

  // diode fault: captured once at first strobe, reset-only clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_done_q <= 1'b0;
      diode_q    <= 1'b0;
    end else if (cycle_i && !pwr_done_q) begin
      pwr_done_q <= 1'b1;
      diode_q    <= diode_flt_i;
    end
  end

  always_comb begin
    lim_sts_o = '0;
    evt_sts_o = '0;
    for (int k = 0; k < NT; k++) begin
      lim_sts_o[2*k]           = chan_q[k].hi;
      lim_sts_o[2*k+1]         = chan_q[k].lo;
      evt_sts_o[CRIT_BASE + k] = chan_q[k].crit;
    end
    evt_sts_o[ALM_BIT]   = alarm_q;
    evt_sts_o[FLT_BIT]   = fault_q;
    evt_sts_o[DIODE_BIT] = diode_q;
    evt_sts_o[EXT_BIT]   = ext_q;
  end

  assign irq_no = ~(|temp_irq |
                    (chan_en_i[FAN_EN] & (alarm_q | fault_q)) |
                    ext_q);
endmodule

// File: rtl/stat_flag_chk.sv
module stat_flag_chk
  import stat_pkg::*;
#(
  parameter int unsigned NUM_REMOTE = 2,
  localparam int unsigned NT = NUM_REMOTE + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cycle_i,
  input logic [NT-1:0]    temp_hi_i,
  input logic [NT-1:0]    temp_lo_i,
  input logic             tach_fail_i,
  input logic             ext_pull_i,
  input logic [NT:0]      chan_en_i,
  input logic             rd_lim_i,
  input logic             rd_evt_i,
  input logic [REG_W-1:0] lim_sts_o,
  input logic [REG_W-1:0] evt_sts_o,
  input logic             irq_no
);
  logic [REG_W-1:0] irq_bits;
  assign irq_bits = evt_sts_o & ~(REG_W'(1) << DIODE_BIT);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r1: assert (irq_no && lim_sts_o == '0 && evt_sts_o == '0)
        else $error("reset state");
    end
  end

  p_lim_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_i && temp_hi_i[0] && chan_en_i[0] |=> lim_sts_o[0]);

  p_lim_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lim_i && !cycle_i |=> lim_sts_o == '0);

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lim_i && cycle_i && temp_lo_i[0] && chan_en_i[0] |=> lim_sts_o[1]);

  p_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tach_fail_i && chan_en_i[NT] |=> evt_sts_o[FLT_BIT]);

  p_diode_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_sts_o[DIODE_BIT] |=> evt_sts_o[DIODE_BIT]);

  p_crit_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_i && !cycle_i |=> evt_sts_o[CRIT_BASE +: NT] == '0);

  p_ext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_pull_i |=> evt_sts_o[CRIT_BASE + NT]);

  p_disable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i[0] |=> lim_sts_o[1:0] == 2'b00 && !evt_sts_o[CRIT_BASE]);

  p_irq_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> (|lim_sts_o) || (|irq_bits));

  p_irq_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_sts_o == '0 && irq_bits == '0 |-> irq_no);
endmodule

bind stat_flag_ctl stat_flag_chk #(.NUM_REMOTE(NUM_REMOTE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cycle_i    (cycle_i),
  .temp_hi_i  (temp_hi_i),
  .temp_lo_i  (temp_lo_i),
  .tach_fail_i(tach_fail_i),
  .ext_pull_i (ext_pull_i),
  .chan_en_i  (chan_en_i),
  .rd_lim_i   (rd_lim_i),
  .rd_evt_i   (rd_evt_i),
  .lim_sts_o  (lim_sts_o),
  .evt_sts_o  (evt_sts_o),
  .irq_no     (irq_no)
);

// File: tb/sim_stat_flag_ctl.sv
module sim_stat_flag_ctl;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cyc = 1'b0;
  logic [NT-1:0] thi = '0, tlo = '0, cov = '0, ccool = '0;
  logic          alarm = 1'b0, tach = 1'b0, dflt = 1'b1, ext = 1'b0;
  logic [NT:0]   cen = '0;
  logic          rd_lim = 1'b0, rd_evt = 1'b0;
  logic [7:0]    lim_sts, evt_sts;
  logic          irq_n;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  stat_flag_ctl #(.NUM_REMOTE(NT-1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cyc),
    .temp_hi_i(thi), .temp_lo_i(tlo), .crit_over_i(cov), .crit_cool_i(ccool),
    .fan_alarm_i(alarm), .tach_fail_i(tach), .diode_flt_i(dflt),
    .ext_pull_i(ext), .chan_en_i(cen), .rd_lim_i(rd_lim), .rd_evt_i(rd_evt),
    .lim_sts_o(lim_sts), .evt_sts_o(evt_sts), .irq_no(irq_n)
  );

  // behavioural reference
  bit [NT-1:0] m_hi, m_lo, m_crit, m_arm;
  bit m_alm, m_flt, m_dio, m_ext, m_seen, m_pwr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_crit = '0; m_arm = '1;
      m_alm = 0; m_flt = 0; m_dio = 0; m_ext = 0; m_seen = 0; m_pwr = 0;
    end else begin
      for (int k = 0; k < NT; k++) begin
        bit csetk;
        csetk = cyc && cov[k] && m_arm[k] && cen[k];
        if (!cen[k]) begin m_hi[k] = 0; m_lo[k] = 0; m_crit[k] = 0; end
        else begin
          if (cyc && thi[k]) m_hi[k] = 1; else if (rd_lim) m_hi[k] = 0;
          if (cyc && tlo[k]) m_lo[k] = 1; else if (rd_lim) m_lo[k] = 0;
          if (csetk) m_crit[k] = 1; else if (rd_evt) m_crit[k] = 0;
        end
        if (csetk) m_arm[k] = 0; else if (cyc && ccool[k]) m_arm[k] = 1;
      end
      if (!cen[NT]) begin m_alm = 0; m_flt = 0; end
      else begin
        if (cyc && alarm && !m_seen) m_alm = 1; else if (rd_evt) m_alm = 0;
        if (tach) m_flt = 1; else if (rd_evt) m_flt = 0;
      end
      if (cyc) m_seen = alarm;
      if (cyc && !m_pwr) begin m_dio = dflt; m_pwr = 1; end
      if (ext) m_ext = 1; else if (rd_evt) m_ext = 0;
    end
  end

  task automatic check();
    logic [7:0] el, ee;
    logic ei;
    el = '0; ee = '0;
    for (int k = 0; k < NT; k++) begin
      el[2*k] = m_hi[k]; el[2*k+1] = m_lo[k]; ee[3+k] = m_crit[k];
    end
    ee[0] = m_alm; ee[1] = m_flt; ee[2] = m_dio; ee[3+NT] = m_ext;
    ei = !((|((m_hi | m_lo | m_crit) & cen[NT-1:0])) ||
           (cen[NT] && (m_alm || m_flt)) || m_ext);
    checks += 3;
    if (lim_sts !== el) begin
      fails++; $display("FAIL %s limit reg actual %h expected %h", cur_req, lim_sts, el);
    end
    if (evt_sts !== ee) begin
      fails++; $display("FAIL %s event reg actual %h expected %h", cur_req, evt_sts, ee);
    end
    if (irq_n !== ei) begin
      fails++; $display("FAIL %s irq_no actual %b expected %b", cur_req, irq_n, ei);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check();
    end
  endtask

  task automatic strobe();
    cyc = 1; tick(); cyc = 0; tick();
  endtask

  task automatic read_evt();
    rd_evt = 1; tick(); rd_evt = 0; tick();
  endtask

  task automatic read_lim();
    rd_lim = 1; tick(); rd_lim = 0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    tick(2);
    rst_n = 1; tick(2);

    // R2: level flags and re-check
    cur_req = "R2";
    cen = '1; thi = 3'b001; tlo = 3'b100;
    strobe();               // diode captured here too
    read_lim();
    strobe();               // reasserted while condition holds
    thi = '0; tlo = '0;
    read_lim();
    strobe();

    // R3: read data before clear, event read keeps diode
    cur_req = "R3";
    thi = 3'b010; strobe(); thi = '0;
    rd_lim = 1; tick(); rd_lim = 0; tick();

    // R4: set and read in same clock
    cur_req = "R4";
    tlo = 3'b010; cyc = 1; rd_lim = 1; tick();
    cyc = 0; rd_lim = 0; tlo = '0; tick();
    read_lim();

    // R5: alarm speed edge rule
    cur_req = "R5";
    alarm = 1; strobe(); strobe();
    read_evt();
    strobe(); strobe();
    alarm = 0; strobe();
    alarm = 1; strobe();
    read_evt();

    // R6: every tach failure
    cur_req = "R6";
    tach = 1; tick(); tach = 0; tick();
    read_evt();
    tach = 1; tick(); tach = 0; tick();
    read_evt();

    // R7: diode sticky, enable-independent
    cur_req = "R7";
    read_evt();
    cen = 4'b1101; tick(2);
    cen = '0; tick(2);
    cen = '1; tick();

    // R8: critical hysteresis
    cur_req = "R8";
    cov = 3'b010; strobe();
    read_evt();
    strobe();               // still over, not armed
    cov = '0; ccool = 3'b010; strobe();
    ccool = '0; cov = 3'b010; strobe();
    cov = '0; read_evt();

    // R9: external pull
    cur_req = "R9";
    ext = 1; tick();
    rd_evt = 1; tick();     // held pull wins over read
    ext = 0; tick();
    rd_evt = 0; tick();

    // R10: channel enables
    cur_req = "R10";
    thi = 3'b111; strobe();
    cen = 4'b1110; tick(2);
    strobe();
    cov = 3'b001; strobe(); cov = '0;
    cen = 4'b0111; tach = 1; tick(); tach = 0; tick();
    cen = '1; thi = '0;
    read_lim();

    // R11: interrupt tracks enabled flags
    cur_req = "R11";
    tach = 1; tick(); tach = 0;
    cen = 4'b0111; tick();
    cen = '1; tick();
    read_evt();
    read_lim();
    tick(2);

    finish_run();
  end
endmodule